// File: doc/BRIEF.md
# Row/Column Multicast Configuration Loader

This block streams configuration words from a shared configuration memory into a two-dimensional array of processing elements over one broadcast bus. A host chooses the targets by writing a row mask and a column mask. An element takes part in a transfer only when both its row bit and its column bit are set. The masks can name a single element, any rectangular group or the whole array, so one region can be reloaded while the rest keeps running.

A transfer begins when `start` is pulsed with a memory address. Every transfer has the same frame: five setup cycles, one cycle per payload word, and one closing cycle. In the setup cycles the block reads a header word that gives the payload length and the destination. The destination is either the instruction store or the interconnect select registers. This lets a topology change be sent without resending programs. Each element has its own small loader FSM. All loaders run in lockstep with the sequencer, and each one drives a write enable for its element's local storage. The write address and data are shared by all elements. An instruction wider than the bus occupies consecutive payload words; a 79-bit instruction on a 32-bit bus needs three words.

Top module: `mcast_cfg_ctrl`

## Requirements
- R1: When `start` is sampled high while idle, `busy` is high for exactly N+6 cycles: five setup cycles, N payload cycles and one closing cycle. N is the header's payload count.
- R2: The header is the memory word at `start_addr`. Bits [7:0] hold the payload count N. Bit 8 selects the destination: 1 for the interconnect select registers, 0 for the instruction store. Throughout the payload, `wr_icn` equals bit 8.
- R3: Payload word k (k = 0..N-1) is written in the (6+k)-th cycle after the start edge. In that cycle `wr_addr` = k and `wr_data` = the memory word at `start_addr`+1+k.
- R4: Element e = row*COLS + col is selected when row-mask bit `row` and column-mask bit `col` are both set. `host_we` with `host_col`=0 writes the row mask from `host_wdata`; with `host_col`=1 it writes the column mask. Every selected element gets `el_we` in every payload cycle.
- R5: An element that is not selected never sees its `el_we` bit high during the transfer.
- R6: `done` is a single-cycle pulse in the cycle after the closing cycle (cycle N+7 after the start edge). `busy` is low in that cycle.
- R7: A `start` pulse that arrives while `busy` is high is ignored and does not change the timing of the running transfer.
- R8: The masks are sampled when a start is accepted. Mask writes made during a transfer affect only the next transfer.
- R9: A header count of 0 gives a 6-cycle frame with no write enable.
- R10: After reset the block is idle: `busy`, `done` and all `el_we` are low, and both masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host mask write strobe |
| host_col | input | 1 | 0: write row mask, 1: write column mask |
| host_wdata | input | MASK_W | Mask value |
| start | input | 1 | Start a transfer (ignored while busy) |
| start_addr | input | AW | Memory address of the header word |
| busy | output | 1 | Transfer frame in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Configuration memory read address (one-cycle read latency) |
| mem_rdata | input | BUS_W | Configuration memory read data |
| el_we | output | ROWS*COLS | Per-element write enable |
| wr_icn | output | 1 | Destination of the current write: 1 interconnect, 0 instructions |
| wr_addr | output | CNT_W | Word index within the destination |
| wr_data | output | BUS_W | Broadcast configuration word |

## Verification
The selection logic is tested with a single element, a rectangular block, the whole array, an empty mask and random mask pairs. Each pattern separates an AND of the row and column bits from an OR, and catches row/column index mix-ups. The tests also use payload lengths of 0, 2, 3 and 12 plus random ones, with both destinations. These show whether the frame length follows the header and whether the destination bit reaches `wr_icn`. A start pulse and mask writes injected in the middle of a transfer show whether the running frame is protected and the masks are latched per transfer.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
   localparam int SETUP_CYC  = 5;
   localparam int HDR_BCAST  = 2;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_PAY,
      SQ_END
   } seq_st_t;

   typedef enum logic {
      LD_IDLE,
      LD_LOAD
   } ld_st_t;
endpackage

// File: rtl/mcc_mask_regs.sv
module mcc_mask_regs #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_col,
   input  logic [MASK_W-1:0] host_wdata,
   output logic [ROWS-1:0]   row_mask,
   output logic [COLS-1:0]   col_mask
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_mask <= '0;
         col_mask <= '0;
      end else if (host_we) begin
         if (host_col) col_mask <= host_wdata[COLS-1:0];
         else          row_mask <= host_wdata[ROWS-1:0];
      end
   end
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int BUS_W = 32,
   parameter int AW    = 6,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic [ROWS-1:0]  row_mask,
   input  logic [COLS-1:0]  col_mask,
   input  logic [BUS_W-1:0] mem_rdata,
   output logic             busy,
   output logic             done,
   output logic [AW-1:0]    mem_addr,
   output logic             hdr_stb,
   output logic             pay_valid,
   output logic             end_stb,
   output logic             icn,
   output logic [CNT_W-1:0] pidx,
   output logic [ROWS-1:0]  row_snap,
   output logic [COLS-1:0]  col_snap
);
   localparam logic [2:0] LAST_SETUP = 3'(SETUP_CYC - 1);
   localparam logic [2:0] BCAST_AT   = 3'(HDR_BCAST);

   seq_st_t          st;
   logic [2:0]       cnt;
   logic [AW-1:0]    ptr;
   logic [CNT_W-1:0] nwords;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         cnt      <= '0;
         ptr      <= '0;
         nwords   <= '0;
         icn      <= 1'b0;
         pidx     <= '0;
         done     <= 1'b0;
         row_snap <= '0;
         col_snap <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  st       <= SQ_SETUP;
                  cnt      <= '0;
                  ptr      <= start_addr;
                  row_snap <= row_mask;
                  col_snap <= col_mask;
               end
            end
            SQ_SETUP: begin
               cnt <= cnt + 3'd1;
               if (cnt == 3'd0 || cnt == LAST_SETUP) ptr <= ptr + AW'(1);
               if (cnt == 3'd1) begin
                  nwords <= mem_rdata[CNT_W-1:0];
                  icn    <= mem_rdata[CNT_W];
               end
               if (cnt == LAST_SETUP) begin
                  pidx <= '0;
                  st   <= (nwords == '0) ? SQ_END : SQ_PAY;
               end
            end
            SQ_PAY: begin
               ptr  <= ptr + AW'(1);
               pidx <= pidx + CNT_W'(1);
               if (pidx == nwords - CNT_W'(1)) st <= SQ_END;
            end
            SQ_END: begin
               st   <= SQ_IDLE;
               done <= 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st != SQ_IDLE);
   assign mem_addr  = ptr;
   assign hdr_stb   = (st == SQ_SETUP) && (cnt == BCAST_AT);
   assign pay_valid = (st == SQ_PAY);
   assign end_stb   = (st == SQ_END);
endmodule

// File: rtl/mcc_loader.sv
module mcc_loader
   import mcc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hdr_stb,
   input  logic sel,
   input  logic pay_valid,
   input  logic end_stb,
   output logic we
);
   ld_st_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= LD_IDLE;
      end else begin
         unique case (st)
            LD_IDLE: if (hdr_stb && sel) st <= LD_LOAD;
            LD_LOAD: if (end_stb) st <= LD_IDLE;
            default: st <= LD_IDLE;
         endcase
      end
   end

   assign we = (st == LD_LOAD) && pay_valid;
endmodule

// File: rtl/mcast_cfg_ctrl.sv
module mcast_cfg_ctrl #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int BUS_W  = 32,
   parameter int AW     = 6,
   parameter int CNT_W  = 8,
   localparam int NEL   = ROWS * COLS,
   localparam int MASK_W = (ROWS > COLS) ? ROWS : COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_col,
   input  logic [MASK_W-1:0] host_wdata,
   input  logic              start,
   input  logic [AW-1:0]     start_addr,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     mem_addr,
   input  logic [BUS_W-1:0]  mem_rdata,
   output logic [NEL-1:0]    el_we,
   output logic              wr_icn,
   output logic [CNT_W-1:0]  wr_addr,
   output logic [BUS_W-1:0]  wr_data
);
   if (ROWS < 1 || COLS < 1) begin : g_bad_dim
      $error("mcast_cfg_ctrl: array needs at least one row and column");
   end
   if (BUS_W < CNT_W + 1) begin : g_bad_bus
      $error("mcast_cfg_ctrl: bus too narrow for header fields");
   end

   logic [ROWS-1:0]  row_mask, row_snap;
   logic [COLS-1:0]  col_mask, col_snap;
   logic             hdr_stb, pay_valid, end_stb;

   mcc_mask_regs #(.ROWS(ROWS), .COLS(COLS), .MASK_W(MASK_W)) i_masks (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_col(host_col),
      .host_wdata(host_wdata), .row_mask(row_mask), .col_mask(col_mask)
   );

   mcc_seq #(.ROWS(ROWS), .COLS(COLS), .BUS_W(BUS_W), .AW(AW), .CNT_W(CNT_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .row_mask(row_mask), .col_mask(col_mask), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .mem_addr(mem_addr), .hdr_stb(hdr_stb),
      .pay_valid(pay_valid), .end_stb(end_stb), .icn(wr_icn), .pidx(wr_addr),
      .row_snap(row_snap), .col_snap(col_snap)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         mcc_loader i_ld (
            .clk(clk), .rst_n(rst_n), .hdr_stb(hdr_stb),
            .sel(row_snap[r] & col_snap[c]), .pay_valid(pay_valid),
            .end_stb(end_stb), .we(el_we[r*COLS+c])
         );
      end
   end

   assign wr_data = mem_rdata;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int NEL = ROWS * COLS
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [NEL-1:0]  el_we,
   input logic [ROWS-1:0] row_mask,
   input logic [COLS-1:0] col_mask
);
   logic [NEL-1:0] exp_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_sel <= '0;
      end else if (start && !busy) begin
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               exp_sel[r*COLS+c] <= row_mask[r] & col_mask[c];
      end
   end

   AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (|el_we) |-> busy);                                        // R3
   AST_WE_ALL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (|el_we) |-> (el_we == exp_sel));                          // R4
   AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (el_we & ~exp_sel) == '0);                                 // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                           // R6
   AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                          // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));                       // R7
endmodule

bind mcast_cfg_ctrl mcc_checker #(.ROWS(ROWS), .COLS(COLS)) i_mcc_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .el_we(el_we), .row_mask(row_mask), .col_mask(col_mask)
);

// File: tb/test_mcast_cfg_ctrl.sv
module test_mcast_cfg_ctrl;
   localparam int ROWS = 4, COLS = 4, BUS_W = 32, AW = 6, CNT_W = 8;
   localparam int NEL = ROWS * COLS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_we = 1'b0, host_col = 1'b0;
   logic [3:0]       host_wdata = '0;
   logic             start = 1'b0;
   logic [AW-1:0]    start_addr = '0;
   logic             busy, done, wr_icn;
   logic [AW-1:0]    mem_addr;
   logic [BUS_W-1:0] mem_rdata, wr_data;
   logic [NEL-1:0]   el_we;
   logic [CNT_W-1:0] wr_addr;
   logic [BUS_W-1:0] mem [64];

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

   mcast_cfg_ctrl #(.ROWS(ROWS), .COLS(COLS), .BUS_W(BUS_W), .AW(AW), .CNT_W(CNT_W)) i_mcast_cfg_ctrl (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_col(host_col),
      .host_wdata(host_wdata), .start(start), .start_addr(start_addr),
      .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .el_we(el_we), .wr_icn(wr_icn), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NEL-1:0] sel_of(input logic [3:0] rm, input logic [3:0] cm);
      logic [NEL-1:0] s = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            s[r*COLS+c] = rm[r] & cm[c];
      return s;
   endfunction

   task automatic host_write(input bit col, input logic [3:0] v);
      @(negedge clk);
      host_we = 1'b1; host_col = col; host_wdata = v;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // Runs one transfer; rm/cm are the masks expected to apply.
   // poke: mid-frame mask writes (pr/pc) and an extra start pulse.
   task automatic xfer(input logic [AW-1:0] a, input logic [3:0] rm, input logic [3:0] cm,
                       input bit wr_masks, input bit poke, input logic [3:0] pr, input logic [3:0] pc);
      int n;
      bit kind;
      logic [NEL-1:0] sel;
      int wcount = 0, busy_cnt = 0;
      n    = int'(mem[a][7:0]);
      kind = mem[a][8];
      sel  = sel_of(rm, cm);
      if (wr_masks) begin
         host_write(1'b0, rm);
         host_write(1'b1, cm);
      end
      @(negedge clk);
      start = 1'b1; start_addr = a;
      for (int t = 1; t <= n + 8; t++) begin
         @(negedge clk);
         start = 1'b0; host_we = 1'b0;
         if (poke && t == 2) begin host_we = 1'b1; host_col = 1'b0; host_wdata = pr; end
         if (poke && t == 3) begin host_we = 1'b1; host_col = 1'b1; host_wdata = pc; start = 1'b1; start_addr = a; end
         if (busy) busy_cnt++;
         chk(busy == (t <= n + 6), "R1 busy frame", {31'd0, busy}, {31'd0, t <= n + 6});
         chk(done == (t == n + 7), "R6 done pulse", {31'd0, done}, {31'd0, t == n + 7});
         if (t >= 6 && t <= n + 5) begin
            chk(el_we == sel, "R4 R5 selection", 32'(el_we), 32'(sel));
            if (|el_we) begin
               wcount++;
               chk(wr_addr == CNT_W'(t - 6), "R3 word index", 32'(wr_addr), 32'(t - 6));
               chk(wr_data == mem[a + AW'(t - 5)], "R3 word data", wr_data, mem[a + AW'(t - 5)]);
               chk(wr_icn == kind, "R2 destination", {31'd0, wr_icn}, {31'd0, kind});
            end
         end else begin
            chk(el_we == '0, "R5 R9 no write outside payload", 32'(el_we), 32'd0);
         end
      end
      start = 1'b0; host_we = 1'b0;
      chk(busy_cnt == n + 6, "R1 R7 frame length", 32'(busy_cnt), 32'(n + 6));
      chk(wcount == ((sel != '0) ? n : 0), "R3 R9 write count", 32'(wcount), 32'((sel != '0) ? n : 0));
   endtask

   task automatic set_hdr(input logic [AW-1:0] a, input int n, input bit icn);
      mem[a] = {$urandom() & 32'hffff_fe00} | {23'd0, icn, 8'(n)};
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < 64; i++) mem[i] = $urandom();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy && !done, "R10 idle after reset", {30'd0, busy, done}, 32'd0);
      chk(el_we == '0, "R10 no enables after reset", 32'(el_we), 32'd0);
      // R10 masks zero: a transfer with untouched masks writes nothing
      set_hdr(6'd0, 2, 1'b0);
      xfer(6'd0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, 4'h0);
      // R4 unicast, 12-word program (four 3-word instructions, 18-cycle frame)
      set_hdr(6'd2, 12, 1'b0);
      xfer(6'd2, 4'b0010, 4'b0100, 1'b1, 1'b0, 4'h0, 4'h0);
      // R2 whole array, interconnect data
      set_hdr(6'd20, 12, 1'b1);
      xfer(6'd20, 4'hf, 4'hf, 1'b1, 1'b0, 4'h0, 4'h0);
      // R7 R8 rectangle with a mid-frame start and mask writes
      set_hdr(6'd40, 3, 1'b0);
      xfer(6'd40, 4'b0011, 4'b1100, 1'b1, 1'b1, 4'b1000, 4'b0001);
      // R8 next transfer uses the masks written mid-frame
      set_hdr(6'd45, 2, 1'b1);
      xfer(6'd45, 4'b1000, 4'b0001, 1'b0, 1'b0, 4'h0, 4'h0);
      // R5 empty column mask: nothing written
      set_hdr(6'd50, 4, 1'b0);
      xfer(6'd50, 4'hf, 4'h0, 1'b1, 1'b0, 4'h0, 4'h0);
      // R9 zero-length frame
      set_hdr(6'd56, 0, 1'b1);
      xfer(6'd56, 4'hf, 4'hf, 1'b1, 1'b0, 4'h0, 4'h0);
      // random masks, lengths and destinations
      for (int k = 0; k < 20; k++) begin
         logic [AW-1:0] a;
         int n;
         n = int'($urandom_range(0, 10));
         a = AW'($urandom_range(0, 63 - n - 1));
         set_hdr(a, n, 1'($urandom()));
         xfer(a, 4'($urandom()), 4'($urandom()), 1'b1, 1'($urandom_range(0, 3) == 0),
              4'($urandom()), 4'($urandom()));
      end
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule